// File: doc/BRIEF.md
# SAR Converter Control Sequencer

This block is the digital control core of a 16-bit successive-approximation converter. It watches an active-low chip-select strobe and a read/convert select line. Counting the chip-select falling edges, it moves through four phases: wake-up into tracking, conversion, a hold phase that keeps the result, and readout. During conversion it drives a trial code to an external DAC and samples one comparator bit per clock. The finished code reaches the parallel three-state bus only when a readout is requested.

Both strobe inputs pass through a two-stage synchronizer, and edges are found on the synchronized copy. The converter's analog parts are not modelled. The comparator decision is a plain input, and the powered-down condition appears only as a status flag. An active-high reset input asserts asynchronously. Its release is synchronized inside the block.

Top module: `sarc_sequencer`

## Requirements
- R1: While reset is applied, and on leaving it, the block is powered down (`pwr_down_o`=1), not busy, not tracking, `dac_code_o`=0 and the bus floats (`dq_oe_o`=0).
- R2: From the powered-down phase, a chip-select falling edge with read/convert low (0 = convert) enters tracking (`track_o`=1, `pwr_down_o`=0). A falling edge with read/convert high leaves the block powered down.
- R3: The next falling edge during tracking starts a conversion. `busy_o` is then high for exactly 16 clock cycles.
- R4: The conversion resolves one bit per clock, from bit 15 down to bit 0. In step k (k = 0..15), `dac_code_o` equals the bits already decided above position 15-k, with bit 15-k set and all lower bits clear. A bit is kept when `cmp_i`=1, which means the input is at or above the trial code. With an ideal comparator, the result equals the input code.
- R5: Chip-select edges that arrive while `busy_o` is high have no effect. After the conversion, the block holds its result with the bus floating.
- R6: In the hold phase, a falling edge with read/convert high (1 = read) drives the result onto `dq_o` and raises `dq_oe_o`. The result stays stable for as long as the bus is driven.
- R7: In the hold phase, a falling edge with read/convert low returns to tracking without driving the bus. The next falling edge starts a fresh conversion.
- R8: A chip-select rising edge during readout floats the bus and returns the block to the powered-down phase.
- R9: A phase change shows on the outputs after the third rising clock edge that follows the input change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Active-high reset, asynchronous assert, synchronized release |
| cs_n_i | input | 1 | Active-low chip-select strobe (asynchronous) |
| rd_cvt_i | input | 1 | Read/convert select, 1 = read, 0 = convert (asynchronous) |
| cmp_i | input | 1 | Comparator decision, 1 = input at or above trial code |
| dac_code_o | output | 16 | Trial code for the external DAC |
| busy_o | output | 1 | High while a conversion is in progress |
| track_o | output | 1 | High during the tracking phase |
| pwr_down_o | output | 1 | High while powered down |
| dq_oe_o | output | 1 | High while the data bus is driven |
| dq_o | output | 16 | Three-state result bus |

## Verification
Every strobe change is applied half a clock before an edge and takes three rising edges to show: two synchronizer stages, then the phase register. The bench samples at the falling edge after the third rising edge. In chosen spots it also samples after the second rising edge, to confirm that nothing has changed yet. Once busy rises, each trial code appears one clock after the previous one, so the bench compares 16 consecutive samples against codes it derives from the input value. It expects busy to drop after the sixteenth step. The readout value is checked three edges after the read strobe, across a sweep of input codes that covers the extremes, every single-bit code and a pseudo-random set.

// File: rtl/sarc_pkg.sv
package sarc_pkg;

  typedef enum logic [2:0] {
    PH_SLEEP,
    PH_TRACK,
    PH_CONV,
    PH_HOLD,
    PH_READ
  } phase_e;

endpackage

// File: rtl/sarc_sync.sv
module sarc_sync #(
  parameter int          NB      = 2,
  parameter int          STAGES  = 2,
  parameter logic [NB-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] din,
  output logic [NB-1:0] dout,
  output logic [NB-1:0] dprev
);

  logic [NB-1:0] stage_q [STAGES];
  logic [NB-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [NB-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign dout  = stage_q[STAGES-1];
  assign dprev = prev_q;

endmodule

// File: rtl/sarc_fsm.sv
module sarc_fsm
  import sarc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_fall,
  input  logic   cs_rise,
  input  logic   rd_sel,
  input  logic   sar_last,
  output phase_e phase,
  output logic   conv_start
);

  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_SLEEP: if (cs_fall && !rd_sel) phase_d = PH_TRACK;
      PH_TRACK: if (cs_fall)            phase_d = PH_CONV;
      PH_CONV:  if (sar_last)           phase_d = PH_HOLD;
      PH_HOLD:  if (cs_fall)            phase_d = rd_sel ? PH_READ : PH_TRACK;
      PH_READ:  if (cs_rise)            phase_d = PH_SLEEP;
      default:                          phase_d = PH_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_SLEEP;
    else        phase_q <= phase_d;
  end

  assign phase      = phase_q;
  assign conv_start = (phase_q == PH_TRACK) && cs_fall;

  AST_WAKE_NEEDS_CONVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SLEEP && cs_fall && rd_sel) |=> phase_q == PH_SLEEP); // R2
  AST_BUSY_IGNORES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CONV && !sar_last) |=> phase_q == PH_CONV); // R5
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READ && cs_rise) |=> phase_q == PH_SLEEP); // R8

endmodule

// File: rtl/sarc_sar.sv
module sarc_sar #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         active,
  input  logic         cmp,
  output logic [W-1:0] code,
  output logic         last
);

  localparam int IW = $clog2(W);
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  logic [W-1:0]  code_q, code_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          en;

  assign en = start | active;

  always_comb begin
    code_d = code_q;
    idx_d  = idx_q;
    if (start) begin
      code_d          = '0;
      code_d[TOP_IDX] = 1'b1;
      idx_d           = TOP_IDX;
    end else if (active) begin
      code_d[idx_q] = cmp;
      if (idx_q != '0) begin
        code_d[idx_q - 1'b1] = 1'b1;
        idx_d                = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      code_q <= code_d;
      idx_q  <= idx_d;
    end
  end

  assign code = code_q;
  assign last = active && (idx_q == '0);

  // assertion support: length of the active window
  logic [IW:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (start)  len_q <= '0;
    else if (active) len_q <= len_q + 1'b1;
  end

  AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> len_q == (IW+1)'(W)); // R3
  AST_BIT_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> code_q[$past(idx_q)] == $past(cmp)); // R4

endmodule

// File: rtl/sarc_bus.sv
module sarc_bus #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         drive,
  input  logic [W-1:0] data,
  output logic [W-1:0] dq,
  output logic         oe
);

  assign oe = drive;
  assign dq = drive ? data : {W{1'bz}};

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && $past(drive)) |-> $stable(data)); // R6

endmodule

// File: rtl/sarc_sequencer.sv
module sarc_sequencer
  import sarc_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_i,
  input  logic         cs_n_i,
  input  logic         rd_cvt_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_code_o,
  output logic         busy_o,
  output logic         track_o,
  output logic         pwr_down_o,
  output logic         dq_oe_o,
  output logic [W-1:0] dq_o
);

  localparam int NB = 2;
  localparam logic [NB-1:0] SYNC_RST = 2'b01; // bit0: chip-select idles high

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk or posedge rst_i) begin
    if (rst_i) rst_pipe_q <= '0;
    else       rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  logic [NB-1:0] sync_now, sync_prev;
  logic          cs_fall, cs_rise, rd_sel;

  sarc_sync #(.NB(NB), .STAGES(SYNC_DEPTH), .RST_VAL(SYNC_RST)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({rd_cvt_i, cs_n_i}),
    .dout  (sync_now),
    .dprev (sync_prev)
  );

  assign cs_fall = sync_prev[0] & ~sync_now[0];
  assign cs_rise = ~sync_prev[0] & sync_now[0];
  assign rd_sel  = sync_now[1];

  phase_e       phase;
  logic         conv_start, sar_last;
  logic [W-1:0] code;

  sarc_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_fall    (cs_fall),
    .cs_rise    (cs_rise),
    .rd_sel     (rd_sel),
    .sar_last   (sar_last),
    .phase      (phase),
    .conv_start (conv_start)
  );

  sarc_sar #(.W(W)) i_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (conv_start),
    .active (phase == PH_CONV),
    .cmp    (cmp_i),
    .code   (code),
    .last   (sar_last)
  );

  sarc_bus #(.W(W)) i_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .drive (phase == PH_READ),
    .data  (code),
    .dq    (dq_o),
    .oe    (dq_oe_o)
  );

  assign dac_code_o = code;
  assign busy_o     = (phase == PH_CONV);
  assign track_o    = (phase == PH_TRACK);
  assign pwr_down_o = (phase == PH_SLEEP);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (pwr_down_o && !busy_o && !dq_oe_o)); // R1
  AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> (!busy_o && !track_o && !pwr_down_o)); // R6

endmodule

// File: tb/test_sarc_sequencer.sv
`timescale 1ns/1ps
module test_sarc_sequencer;

  logic        clk = 1'b0;
  logic        rst_i, cs_n_i, rd_cvt_i, cmp_i;
  logic [15:0] dac_code_o, dq_o, vin;
  logic        busy_o, track_o, pwr_down_o, dq_oe_o;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  assign cmp_i = (vin >= dac_code_o);

  sarc_sequencer i_sarc_sequencer (
    .clk        (clk),
    .rst_i      (rst_i),
    .cs_n_i     (cs_n_i),
    .rd_cvt_i   (rd_cvt_i),
    .cmp_i      (cmp_i),
    .dac_code_o (dac_code_o),
    .busy_o     (busy_o),
    .track_o    (track_o),
    .pwr_down_o (pwr_down_o),
    .dq_oe_o    (dq_oe_o),
    .dq_o       (dq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_flags(input string tag);
    check({tag, " pwr_down"}, pwr_down_o, 1);
    check({tag, " busy"}, busy_o, 0);
    check({tag, " track"}, track_o, 0);
    check({tag, " oe"}, dq_oe_o, 0);
  endtask

  // first edge with convert select: into tracking
  task automatic wake(input bit early);
    rd_cvt_i = 1'b0; cs_n_i = 1'b0;
    if (early) begin
      tick(2);
      check("R9 no wake after two edges", track_o, 0);
      tick(1);
    end else tick(3);
    check("R2 track after wake", track_o, 1);
    check("R2 awake", pwr_down_o, 0);
    cs_n_i = 1'b1; tick(3);
  endtask

  // second edge: conversion with a check of every trial code
  task automatic convert(input logic [15:0] v, input bit poke);
    vin = v;
    cs_n_i = 1'b0; tick(3);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] upper;
      upper = (32'hFFFF << (16 - k)) & 32'hFFFF & {16'h0, v};
      check("R3 busy during step", busy_o, 1);
      check("R4 trial code", dac_code_o, upper | (32'h1 << (15 - k)));
      if (poke && k == 3)  cs_n_i = 1'b1;
      if (poke && k == 7)  cs_n_i = 1'b0;
      if (poke && k == 10) cs_n_i = 1'b1;
      tick(1);
    end
    check("R3 busy low after 16", busy_o, 0);
    check("R5 bus floats in hold", dq_oe_o, 0);
    check("R4 final code", dac_code_o, {16'h0, v});
    cs_n_i = 1'b1; tick(3);
    check("R5 still holding", busy_o | track_o | pwr_down_o | dq_oe_o, 0);
  endtask

  task automatic readout(input logic [15:0] v, input bit early);
    rd_cvt_i = 1'b1; cs_n_i = 1'b0;
    if (early) begin
      tick(2);
      check("R9 no drive after two edges", dq_oe_o, 0);
      tick(1);
    end else tick(3);
    check("R6 bus driven", dq_oe_o, 1);
    check("R6 bus value", dq_o, {16'h0, v});
    tick(2);
    check("R6 value stable", dq_o, {16'h0, v});
    cs_n_i = 1'b1; tick(3);
    check("R8 float after rise", dq_oe_o, 0);
    check("R8 powered down", pwr_down_o, 1);
    rd_cvt_i = 1'b0; tick(1);
  endtask

  initial begin
    logic [15:0] lf;
    rst_i = 1'b1; cs_n_i = 1'b1; rd_cvt_i = 1'b0; vin = 16'h0;
    tick(3);
    idle_flags("R1 in reset");
    check("R1 dac zero", dac_code_o, 0);
    @(negedge clk) rst_i = 1'b0;
    tick(4);
    idle_flags("R1 after release");

    // R2: edge with read select does not wake
    rd_cvt_i = 1'b1; cs_n_i = 1'b0; tick(4);
    idle_flags("R2 read edge ignored");
    cs_n_i = 1'b1; tick(3);
    rd_cvt_i = 1'b0; tick(1);

    wake(1'b1);
    convert(16'hA5C3, 1'b1);
    readout(16'hA5C3, 1'b1);

    // R7: third edge with convert select goes back to tracking
    wake(1'b0);
    convert(16'h1234, 1'b0);
    rd_cvt_i = 1'b0; cs_n_i = 1'b0; tick(3);
    check("R7 back to track", track_o, 1);
    check("R7 no drive", dq_oe_o, 0);
    cs_n_i = 1'b1; tick(3);
    convert(16'hFEDC, 1'b0);
    readout(16'hFEDC, 1'b0);

    // sweep of input codes
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      case (i)
        0: v = 16'h0000; 1: v = 16'hFFFF; 2: v = 16'h8000; 3: v = 16'h7FFF;
        4: v = 16'h0001; 5: v = 16'hFFFE; 6: v = 16'h5555; default: v = 16'hAAAA;
      endcase
      wake(1'b0); convert(v, 1'b0); readout(v, 1'b0);
    end
    for (int b = 0; b < 16; b++) begin
      wake(1'b0); convert(16'h1 << b, 1'b0); readout(16'h1 << b, 1'b0);
    end
    lf = 16'hACE1;
    for (int i = 0; i < 16; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wake(1'b0); convert(lf, 1'b0); readout(lf, 1'b0);
    end

    // R1: reset in the middle of a conversion
    wake(1'b0);
    vin = 16'h3C3C; cs_n_i = 1'b0; tick(8);
    check("R1 busy before reset", busy_o, 1);
    rst_i = 1'b1; #1;
    idle_flags("R1 async reset");
    check("R1 dac cleared", dac_code_o, 0);
    tick(2);
    cs_n_i = 1'b1; rst_i = 1'b0; tick(4);
    idle_flags("R1 after second release");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule